// File: doc/BRIEF.md
# Packed Decimal Adder/Subtractor

This block adds or subtracts two unsigned packed-decimal numbers of `DIGITS` decimal digits each (default 4). Every digit is a 4-bit binary-coded decimal code. Digit `i` sits in bits `[4i+3:4i]`, so the least significant decimal digit occupies the lowest nibble. The carry moves from the lowest digit upward. Each digit slice forms the binary sum of its two digits and the incoming carry. When that sum passes 9, the slice adds six, which wraps the digit back into the range 0..9 and raises a carry into the next digit.

With `op_sub` high, the block forms the difference A − B. Each digit of B is first replaced by its nine's complement (9 − d). A carry of one is then injected at the lowest digit, which turns the nine's complement into the ten's complement. The final carry is not part of the numeric result. Instead it reports the sign: a carry of one means A ≥ B, and a carry of zero raises `neg` and leaves the result as the ten's complement of the magnitude. A separate flag reports any operand nibble that is not a decimal digit. The arithmetic core is combinational, and every output is captured in a register, so results appear one clock after their operands.

Top module: `dec_addsub`

## Requirements
- R1: All outputs are registered. The outputs for operands applied before a rising edge appear after that edge. A synchronous active-high `rst` clears `sum_out`, `cout`, `neg` and `bad_digit` to zero.
- R2: With `op_sub` = 0 and valid digits, `sum_out` equals (A + B) mod 10^DIGITS in packed decimal, and every result nibble is 0..9.
- R3: A digit whose binary sum exceeds 9 is corrected by adding 6 and carries one into the next digit. For example, 0005 + 0007 gives 0012, and 0255 + 0063 gives 0318.
- R4: With `op_sub` = 0, `cout` is 1 exactly when A + B ≥ 10^DIGITS.
- R5: With `op_sub` = 1 and valid digits, `sum_out` equals (A + 10^DIGITS − B) mod 10^DIGITS. For example, 0255 − 0063 gives 0192.
- R6: With `op_sub` = 1, `cout` is 1 exactly when A ≥ B, and `neg` is its inverse. For example, 0021 − 0034 gives 9987 with `neg` = 1.
- R7: Subtracting zero returns A unchanged with `cout` = 1 and `neg` = 0, and subtracting A from itself gives zero with `cout` = 1.
- R8: `bad_digit` is 1 exactly when any nibble of A or B holds 10..15. The arithmetic outputs are then unspecified.
- R9: With `op_sub` = 0, `neg` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 4*DIGITS | Operand A (minuend when subtracting), packed decimal |
| opnd_b | input | 4*DIGITS | Operand B (subtrahend when subtracting), packed decimal |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| sum_out | output | 4*DIGITS | Registered packed-decimal result |
| cout | output | 1 | Registered decimal carry out of the top digit |
| neg | output | 1 | Registered flag: a subtraction gave a negative difference |
| bad_digit | output | 1 | Registered flag: some operand nibble is not a decimal digit |

## Verification
The only state is the output register, so a fault in the slices, the complement stage or the carry chain shows up at the ports one clock after the operands that expose it. The effect is a wrong digit, a nibble above 9, or a wrong carry or sign. A missing decimal correction or a broken carry link only appears for operand pairs whose digit sums cross 9 at that position. For that reason the sweep covers every valid operand pair, in both modes, on a two-digit build. Directed cases on the four-digit default then exercise the longer carry chain.

// File: rtl/dec_addsub_pkg.sv
package dec_addsub_pkg;
  localparam int NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_MAX = 4'd9;

  typedef logic [NIB_W-1:0] nib_t;

  function automatic logic nib_is_dec(input nib_t d);
    return d <= NIB_MAX;
  endfunction
endpackage

// File: rtl/dec_nib_slice.sv
module dec_nib_slice
  import dec_addsub_pkg::*;
(
  input  nib_t x,
  input  nib_t y,
  input  logic cin,
  output nib_t s,
  output logic co
);
  logic [NIB_W:0] raw;
  logic [NIB_W:0] fixed;
  logic           over;

  always_comb begin
    raw   = {1'b0, x} + {1'b0, y} + {{NIB_W{1'b0}}, cin};
    over  = raw > {1'b0, NIB_MAX};
    fixed = raw + (over ? (NIB_W+1)'(6) : '0);
    s     = fixed[NIB_W-1:0];
    co    = over;
  end
endmodule

// File: rtl/dec_nines_comp.sv
module dec_nines_comp
  import dec_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * NIB_W
) (
  input  logic [W-1:0] din,
  input  logic         en,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    nib_t d;
    assign d = din[i*NIB_W +: NIB_W];
    assign dout[i*NIB_W +: NIB_W] = en ? (NIB_MAX - d) : d;
  end
endmodule

// File: rtl/dec_carry_chain.sv
module dec_carry_chain
  import dec_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * NIB_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  logic [DIGITS:0] c;
  assign c[0] = cin;

  for (genvar i = 0; i < DIGITS; i++) begin : g_slice
    dec_nib_slice u_slice (
      .x  (a[i*NIB_W +: NIB_W]),
      .y  (b[i*NIB_W +: NIB_W]),
      .cin(c[i]),
      .s  (s[i*NIB_W +: NIB_W]),
      .co (c[i+1])
    );
  end

  assign co = c[DIGITS];
endmodule

// File: rtl/dec_digit_scan.sv
module dec_digit_scan
  import dec_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * NIB_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         any_bad
);
  logic [2*DIGITS-1:0] bad;
  for (genvar i = 0; i < DIGITS; i++) begin : g_scan
    assign bad[2*i]   = !nib_is_dec(a[i*NIB_W +: NIB_W]);
    assign bad[2*i+1] = !nib_is_dec(b[i*NIB_W +: NIB_W]);
  end
  assign any_bad = |bad;
endmodule

// File: rtl/dec_addsub.sv
module dec_addsub
  import dec_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * NIB_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         op_sub,
  output logic [W-1:0] sum_out,
  output logic         cout,
  output logic         neg,
  output logic         bad_digit
);
  logic [W-1:0] b_eff;
  logic [W-1:0] s_comb;
  logic         c_comb;
  logic         bad_comb;

  dec_nines_comp #(.DIGITS(DIGITS)) u_comp (
    .din (opnd_b),
    .en  (op_sub),
    .dout(b_eff)
  );

  dec_carry_chain #(.DIGITS(DIGITS)) u_chain (
    .a  (opnd_a),
    .b  (b_eff),
    .cin(op_sub),
    .s  (s_comb),
    .co (c_comb)
  );

  dec_digit_scan #(.DIGITS(DIGITS)) u_scan (
    .a      (opnd_a),
    .b      (opnd_b),
    .any_bad(bad_comb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_out   <= '0;
      cout      <= 1'b0;
      neg       <= 1'b0;
      bad_digit <= 1'b0;
    end else begin
      sum_out   <= s_comb;
      cout      <= c_comb;
      neg       <= op_sub & ~c_comb;
      bad_digit <= bad_comb;
    end
  end
endmodule

// File: rtl/dec_addsub_chk.sv
module dec_addsub_chk
  import dec_addsub_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * NIB_W
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         op_sub,
  input logic [W-1:0] sum_out,
  input logic         cout,
  input logic         neg,
  input logic         bad_digit
);
  logic in_ok;
  logic out_ok;

  always_comb begin
    in_ok  = 1'b1;
    out_ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (!nib_is_dec(opnd_a[i*NIB_W +: NIB_W])) in_ok = 1'b0;
      if (!nib_is_dec(opnd_b[i*NIB_W +: NIB_W])) in_ok = 1'b0;
      if (!nib_is_dec(sum_out[i*NIB_W +: NIB_W])) out_ok = 1'b0;
    end
  end

  // R1: reset clears all outputs
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && !cout && !neg && !bad_digit));

  // R2: valid operands always yield decimal result digits
  assert_result_digits_R2: assert property (@(posedge clk) disable iff (rst)
    in_ok |=> out_ok);

  // R9: addition never flags a negative result
  assert_add_not_neg_R9: assert property (@(posedge clk) disable iff (rst)
    !op_sub |=> !neg);

  // R6: sign and carry are exclusive
  assert_neg_no_carry_R6: assert property (@(posedge clk) disable iff (rst)
    neg |-> !cout);

  // R7: subtracting zero returns the minuend with carry set
  assert_sub_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (op_sub && in_ok && opnd_b == '0) |=>
      (sum_out == $past(opnd_a) && cout && !neg));

  // R7: subtracting an operand from itself gives zero
  assert_sub_self_R7: assert property (@(posedge clk) disable iff (rst)
    (op_sub && in_ok && opnd_a == opnd_b) |=> (sum_out == '0 && cout));

  // R8: flag follows operand validity one cycle later
  assert_bad_flag_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (bad_digit == !$past(in_ok)));
endmodule

bind dec_addsub dec_addsub_chk #(.DIGITS(DIGITS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opnd_a   (opnd_a),
  .opnd_b   (opnd_b),
  .op_sub   (op_sub),
  .sum_out  (sum_out),
  .cout     (cout),
  .neg      (neg),
  .bad_digit(bad_digit)
);

// File: tb/dec_addsub_tb.sv
module dec_addsub_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0]  a2, b2, s2;
  logic        sub2, c2, n2, bad2;
  logic [15:0] a4, b4, s4;
  logic        sub4, c4, n4, bad4;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  dec_addsub #(.DIGITS(2)) u_dut (
    .clk(clk), .rst(rst), .opnd_a(a2), .opnd_b(b2), .op_sub(sub2),
    .sum_out(s2), .cout(c2), .neg(n2), .bad_digit(bad2)
  );

  dec_addsub #(.DIGITS(4)) u_dut_w4 (
    .clk(clk), .rst(rst), .opnd_a(a4), .opnd_b(b4), .op_sub(sub4),
    .sum_out(s4), .cout(c4), .neg(n4), .bad_digit(bad4)
  );

  function automatic logic [7:0] enc2(input int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [15:0] enc4(input int v);
    return {4'((v / 1000) % 10), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run4(input int a, input int b, input bit s,
                      input int er, input bit ec, input bit en, input string req);
    a4 = enc4(a); b4 = enc4(b); sub4 = s;
    @(negedge clk);
    chk(s4 == enc4(er), req, int'(s4), int'(enc4(er)));
    chk(c4 == ec, req, int'(c4), int'(ec));
    chk(n4 == en, req, int'(n4), int'(en));
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    a2 = 8'h99; b2 = 8'h99; sub2 = 1'b0;
    a4 = 16'h9999; b4 = 16'h9999; sub4 = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(s2 == 8'h00 && !c2 && !n2 && !bad2, "R1 reset", int'(s2), 0);
    chk(s4 == 16'h0000 && !c4 && !n4 && !bad4, "R1 reset", int'(s4), 0);
    rst = 1'b0;

    // Directed cases on four digits
    run4(5, 7, 1'b0, 12, 1'b0, 1'b0, "R3 5+7");
    run4(255, 63, 1'b0, 318, 1'b0, 1'b0, "R3 255+63");
    run4(9999, 1, 1'b0, 0, 1'b1, 1'b0, "R4 ripple carry");
    run4(255, 63, 1'b1, 192, 1'b1, 1'b0, "R5 255-63");
    run4(21, 34, 1'b1, 9987, 1'b0, 1'b1, "R6 21-34");
    run4(0, 1, 1'b1, 9999, 1'b0, 1'b1, "R6 0-1");
    run4(4821, 0, 1'b1, 4821, 1'b1, 1'b0, "R7 minus zero");
    run4(7777, 7777, 1'b1, 0, 1'b1, 1'b0, "R7 self");

    // R8: bad digits in either operand, each digit position
    for (int p = 0; p < 2; p++) begin
      for (int v = 10; v < 16; v++) begin
        a2 = 8'h00; b2 = 8'h00; sub2 = 1'b0;
        if (p == 0) a2 = 8'(v) << 4; else b2 = 8'(v);
        @(negedge clk);
        chk(bad2 == 1'b1, "R8 bad digit", int'(bad2), 1);
      end
    end

    // Exhaustive sweep on two digits, both modes
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 100; a++) begin
        for (int b = 0; b < 100; b++) begin
          int er;
          bit ec;
          bit en;
          a2 = enc2(a); b2 = enc2(b); sub2 = m[0];
          if (m == 0) begin
            er = (a + b) % 100; ec = (a + b) >= 100; en = 1'b0;
          end else begin
            er = (a + 100 - b) % 100; ec = a >= b; en = a < b;
          end
          @(negedge clk);
          if (m == 0) begin
            chk(s2 == enc2(er), "R2 add result", int'(s2), int'(enc2(er)));
            chk(c2 == ec, "R4 add carry", int'(c2), int'(ec));
            chk(!n2, "R9 add neg", int'(n2), 0);
          end else begin
            chk(s2 == enc2(er), "R5 sub result", int'(s2), int'(enc2(er)));
            chk(c2 == ec && n2 == en, "R6 sub sign", int'({c2, n2}), int'({ec, en}));
          end
          chk(!bad2, "R8 valid", int'(bad2), 0);
        end
      end
    end

    // R1: reset clears after activity
    a2 = 8'h99; b2 = 8'h99; sub2 = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(s2 == 8'h00 && !c2, "R1 re-reset", int'(s2), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule